// File: doc/BRIEF.md
# Alarm Flag Interrupt Controller

This block collects three independent alarm events (a cycle-counter alarm, an interval-timer alarm and a real-time alarm) into sticky status flags. It raises an active-low interrupt request as long as at least one flag is set whose interrupt is enabled. Each flag has its own enable bit, and that bit is active-low: a 0 lets the flag interrupt and a 1 masks it. The counters that produce the alarms sit outside the block and deliver single-cycle strobes.

The host sees one status word at a fixed address on a simple register bus. Reading that word returns the flags as they were before the read and the current enable bits. The read also acknowledges the interrupt: at the clock edge that ends the read, every flag clears. Writing the same address loads the enable bits, so software can silence the request without clearing the flags. An alarm that arrives in the same cycle as the acknowledging read is kept. The request drives an output-enable that pulls the line low and never drives it high. It comes from a two-state machine. `IRQ_IDLE` moves to `IRQ_PULL` on the *raise* transition, when the next flag and enable values hold an enabled flag. `IRQ_PULL` returns to `IRQ_IDLE` on the *release* transition, when none remains. Otherwise each state holds.

Top module: `afic_top`

## Requirements
- R1: While and directly after the synchronous active-high reset, all flags are 0, all enable bits are 1 (masked) and `irq_oe` is 0.
- R2: A 1 on `alarm_stb[i]` at a rising edge sets flag i (bit 0 cycle-counter, bit 1 interval-timer, bit 2 real-time), and the flag stays set until a clearing read.
- R3: After every rising edge, `irq_oe` is 1 exactly when some flag i is 1 while enable bit i is 0. It rises after the same edge that sets such a flag.
- R4: While `rd_en` is 1 and `addr` equals `STATUS_ADDR` (default 0x200), `rd_data` shows the flags in bits 2:0, the enables in bits 5:3 and zeros above, without wait cycles, with the flag values from before the clear.
- R5: A read of `STATUS_ADDR` clears all flags at the edge that ends it, so `irq_oe` drops after that edge unless R6 applies.
- R6: A strobe on `alarm_stb[i]` in the same cycle as a clearing read leaves flag i set after that edge.
- R7: A write with `addr` equal to `STATUS_ADDR` loads the enables from `wdata[5:3]`. Setting an enable to 1 drops `irq_oe` while its flag stays set.
- R8: Reads and writes at any other address return `rd_data` of 0 and change neither flags nor enables. `rd_data` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_stb | input | N_ALARMS (3) | Single-cycle alarm strobes, bit 0 cycle-counter, bit 1 interval, bit 2 real-time |
| addr | input | ADDR_W (10) | Register bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W (8) | Write data, enables in bits 5:3 |
| rd_data | output | DATA_W (8) | Read data, valid in the cycle of the read strobe |
| irq_oe | output | 1 | Interrupt pull-low enable, 1 pulls the line low |

## Verification
The bench builds the block with its default parameters: three alarms, a 10-bit address, 8-bit data and the status word at 0x200. A 10-bit address lets random traffic hit addresses just next to 0x200, so decoding of foreign addresses is exercised. Three flags with three masks give eight mask patterns, and all of them come up under random writes. The flags, masks and strobes mix with acknowledging reads in the same cycle, which brings R6 and the release transition of the state machine within reach.

// File: rtl/afic_pkg.sv
package afic_pkg;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PULL = 1'b1
    } irq_state_e;

    localparam int ALARM_CYC = 0;
    localparam int ALARM_IVL = 1;
    localparam int ALARM_RTC = 2;

endpackage

// File: rtl/afic_flag_bank.sv
module afic_flag_bank #(
    parameter int N_ALARMS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ALARMS-1:0] alarm_stb,
    input  logic                clr,
    output logic [N_ALARMS-1:0] flags_q,
    output logic [N_ALARMS-1:0] flags_d
);

    for (genvar i = 0; i < N_ALARMS; i++) begin : g_flag
        // a new alarm outranks the clear so the event is never dropped
        always_comb begin
            flags_d[i] = alarm_stb[i] | (flags_q[i] & ~clr);
        end

        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= flags_d[i];
        end
    end

endmodule

// File: rtl/afic_regif.sv
module afic_regif #(
    parameter int          N_ALARMS    = 3,
    parameter int          ADDR_W      = 10,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [N_ALARMS-1:0] flags_q,
    output logic [DATA_W-1:0]   rd_data,
    output logic                clr,
    output logic [N_ALARMS-1:0] en_q,
    output logic [N_ALARMS-1:0] en_d
);

    localparam int EN_LSB = N_ALARMS;
    localparam int EN_MSB = 2 * N_ALARMS - 1;

    logic              hit;
    logic [DATA_W-1:0] word;

    always_comb begin
        hit  = (addr == STATUS_ADDR);
        clr  = rd_en & hit;
        en_d = (wr_en & hit) ? wdata[EN_MSB:EN_LSB] : en_q;
    end

    always_comb begin
        word                = '0;
        word[N_ALARMS-1:0]  = flags_q;
        word[EN_MSB:EN_LSB] = en_q;
        rd_data             = clr ? word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '1;
        else     en_q <= en_d;
    end

endmodule

// File: rtl/afic_irq_fsm.sv
module afic_irq_fsm
    import afic_pkg::*;
#(
    parameter int N_ALARMS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ALARMS-1:0] flags_d,
    input  logic [N_ALARMS-1:0] en_d,
    output logic                irq_oe
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       pend_d;

    always_comb begin
        pend_d  = |(flags_d & ~en_d);
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (pend_d)  state_d = IRQ_PULL;
            IRQ_PULL: if (!pend_d) state_d = IRQ_IDLE;
            default:               state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= IRQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_oe = (state_q == IRQ_PULL);
    end

endmodule

// File: rtl/afic_top.sv
module afic_top #(
    parameter int          N_ALARMS    = 3,
    parameter int          ADDR_W      = 10,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ALARMS-1:0] alarm_stb,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq_oe
);

    logic [N_ALARMS-1:0] flags_q;
    logic [N_ALARMS-1:0] flags_d;
    logic [N_ALARMS-1:0] en_q;
    logic [N_ALARMS-1:0] en_d;
    logic                clr;

    afic_regif #(
        .N_ALARMS(N_ALARMS), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
    ) u_regif (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .flags_q(flags_q), .rd_data(rd_data), .clr(clr),
        .en_q(en_q), .en_d(en_d)
    );

    afic_flag_bank #(.N_ALARMS(N_ALARMS)) u_flags (
        .clk(clk), .rst(rst), .alarm_stb(alarm_stb), .clr(clr),
        .flags_q(flags_q), .flags_d(flags_d)
    );

    afic_irq_fsm #(.N_ALARMS(N_ALARMS)) u_fsm (
        .clk(clk), .rst(rst), .flags_d(flags_d), .en_d(en_d), .irq_oe(irq_oe)
    );

endmodule

// File: rtl/afic_checker.sv
module afic_checker #(
    parameter int          N_ALARMS    = 3,
    parameter int          ADDR_W      = 10,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h200
) (
    input logic                clk,
    input logic                rst,
    input logic [N_ALARMS-1:0] alarm_stb,
    input logic [ADDR_W-1:0]   addr,
    input logic                rd_en,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rd_data,
    input logic                irq_oe,
    input logic [N_ALARMS-1:0] flags_q,
    input logic [N_ALARMS-1:0] en_q
);

    logic hit_rd;
    logic hit_wr;
    assign hit_rd = rd_en && (addr == STATUS_ADDR);
    assign hit_wr = wr_en && (addr == STATUS_ADDR);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (flags_q == '0) && (en_q == '1) && !irq_oe);

    p_alarm_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (|alarm_stb) |=> ((flags_q & $past(alarm_stb)) == $past(alarm_stb)));

    p_irq_match_r3: assert property (@(posedge clk) disable iff (rst)
        irq_oe == |(flags_q & ~en_q));

    p_rdata_r4: assert property (@(posedge clk) disable iff (rst)
        hit_rd |-> (rd_data[N_ALARMS-1:0] == flags_q));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (hit_rd && alarm_stb == '0) |=> (flags_q == '0) && !irq_oe);

    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        hit_rd |=> (flags_q == $past(alarm_stb)));

    p_no_phantom_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(alarm_stb)) == '0));

    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !hit_wr |=> $stable(en_q));

    p_idle_read_r8: assert property (@(posedge clk) disable iff (rst)
        !hit_rd |-> (rd_data == '0));

endmodule

bind afic_top afic_checker #(
    .N_ALARMS(N_ALARMS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .alarm_stb(alarm_stb), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rd_data(rd_data),
    .irq_oe(irq_oe), .flags_q(flags_q), .en_q(en_q)
);

// File: tb/sim_afic_top.sv
`timescale 1ns/1ps
module sim_afic_top;

    localparam int N  = 3;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam logic [AW-1:0] SA = 10'h200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  alarm_stb = '0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] m_flags = '0;
    logic [N-1:0] m_en = '1;

    always #4 clk = ~clk;

    afic_top u0 (
        .clk(clk), .rst(rst), .alarm_stb(alarm_stb), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rd_data(rd_data), .irq_oe(irq_oe)
    );

    function automatic logic [DW-1:0] exp_word(logic rd, logic [AW-1:0] a,
                                               logic [N-1:0] f, logic [N-1:0] e);
        logic [DW-1:0] w;
        w = '0;
        if (rd && a == SA) begin
            w[2:0] = f;
            w[5:3] = e;
        end
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag, logic [N-1:0] al, logic [AW-1:0] a,
                        logic rd, logic wr, logic [DW-1:0] wd);
        @(negedge clk);
        alarm_stb = al; addr = a; rd_en = rd; wr_en = wr; wdata = wd;
        #1;
        check({tag, " R4/R8 rd_data"}, 32'(rd_data), 32'(exp_word(rd, a, m_flags, m_en)));
        @(posedge clk);
        if (wr && a == SA) m_en = wd[5:3];
        m_flags = al | (m_flags & ((rd && a == SA) ? 3'b000 : 3'b111));
        #1;
        check({tag, " R3 irq_oe"}, 32'(irq_oe), 32'(|(m_flags & ~m_en)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq after reset", 32'(irq_oe), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        // R1: enables read back masked, flags clear
        step("R1 reset word", '0, SA, 1'b1, 1'b0, '0);
        // R2: masked alarm sets flag, no interrupt
        step("R2 masked set", 3'b010, SA + 10'd1, 1'b0, 1'b0, '0);
        step("R2 hold", '0, '0, 1'b0, 1'b0, '0);
        // R7: unmask all, flag already set raises irq
        step("R7 unmask", '0, SA, 1'b0, 1'b1, 8'h00);
        // R8: foreign read does not clear
        step("R8 foreign read", '0, SA - 10'd1, 1'b1, 1'b0, '0);
        step("R8 foreign write", '0, SA ^ 10'h001, 1'b0, 1'b1, 8'hFF);
        // R5: clearing read
        step("R5 clear read", '0, SA, 1'b1, 1'b0, '0);
        // R2 each alarm individually
        for (int i = 0; i < N; i++) begin
            step("R2 single alarm", 3'(1 << i), '0, 1'b0, 1'b0, '0);
            step("R2 readback", '0, SA, 1'b1, 1'b0, '0);
        end
        // R6: alarm coinciding with clear
        step("R6 set", 3'b001, '0, 1'b0, 1'b0, '0);
        step("R6 race", 3'b100, SA, 1'b1, 1'b0, '0);
        step("R6 readback", '0, SA, 1'b1, 1'b0, '0);
        // R7: masking drops irq while flag stays
        step("R7 set", 3'b010, '0, 1'b0, 1'b0, '0);
        step("R7 mask", '0, SA, 1'b0, 1'b1, 8'h10);
        step("R7 flag kept", '0, SA, 1'b1, 1'b0, '0);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0]  al;
            logic [AW-1:0] a;
            logic          rd, wr;
            al = ($urandom % 4 == 0) ? N'($urandom) : '0;
            case ($urandom % 4)
                0, 1:    a = SA;
                2:       a = SA + AW'($urandom % 3) - 10'd1;
                default: a = AW'($urandom);
            endcase
            rd = ($urandom % 5 == 0);
            wr = ($urandom % 6 == 0);
            step("R2/R5/R6/R7 random", al, a, rd, wr, DW'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule